// File: doc/BRIEF.md
# Hybrid Gated Frequency Counter

This block measures an external clock of roughly 10 MHz against a fast reference clock (250 MHz nominal). It opens a measurement gate of a fixed number of reference cycles (one second by default). Inside that gate it records three quantities. The first is the number of reference cycles that pass before the first rising edge of the input. The second is how many rising edges of the input occur. The third is the number of reference cycles left after the last rising edge. Arithmetic downstream uses these three values to resolve the whole cycles and the partial first and last cycles. This gives sub-hertz resolution.

The measured input is resynchronised and edge-detected in the reference domain. Two counter groups take turns. While one group counts the current gate, the other holds the results of the previous gate and drives the readout ports. At every gate boundary the groups swap roles and a one-cycle valid pulse marks fresh results. The newly active group starts from zero.

Top module: `hyb_freq_counter`

## Requirements
- R1: While reset is asserted, all readout ports, `bank_sel_o` and `valid_o` are 0.
- R2: The pre count of a gate equals the number of gate cycles before the cycle in which the first rising edge is registered. That edge cycle is not counted.
- R3: The main count of a gate equals the number of rising edges registered during that gate.
- R4: The post count equals the number of gate cycles after the last registered rising edge, not counting that edge cycle. It is 0 when the gate saw no edge.
- R5: A gate lasts exactly GATE_CYCLES reference cycles. The first gate begins on the first clock edge after reset release. `bank_sel_o` (0 = group A readable, 1 = group B readable) starts at 0 and toggles at each gate end.
- R6: The readout ports always show the idle group. They do not change between two valid pulses.
- R7: `valid_o` is high for exactly one cycle after each gate end, in the same cycle the new results appear on the readout.
- R8: A rise of `meas_i` sampled by clock edge k is counted by the counters on clock edge k+2. A level held high does not count again. An input already high at reset release counts as one rise. For GATE_CYCLES=60 with the input high from reset, the first results are pre 2, main 1 and post 57.
- R9: A counter group is cleared when it becomes active. A gate with no rising edge reports pre = GATE_CYCLES, main = 0 and post = 0, whatever the group held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| meas_i | input | 1 | Measured clock, asynchronous to clk_i |
| bank_sel_o | output | 1 | Group being read: 0 = A, 1 = B |
| valid_o | output | 1 | One-cycle pulse when new results appear |
| rd_pre_o | output | CNT_W | Pre count of the idle group |
| rd_main_o | output | CNT_W | Edge count of the idle group |
| rd_post_o | output | CNT_W | Post count of the idle group |

## Verification
The bench starts with the input high across reset release. This exposes the two-cycle synchroniser latency and the rule that a held level counts only once. A design with the wrong pipeline depth, or with no edge detection, would report the wrong pre count or a runaway edge count. Gates without any edges test that the new group is cleared and that the post count stays at zero. A design that keeps stale values or starts the tail count early would fail these gates. Square waves of period 2 to 7 and an irregular pulse train place edges on every cycle next to a gate boundary. These catch off-by-one errors in the gate length, an edge counted in the wrong group at the swap, and readout values that move during a gate.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/fc_sync_edge.sv
`timescale 1ns/1ps
module fc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fc_gate_gen.sv
`timescale 1ns/1ps
module fc_gate_gen #(
  parameter int unsigned GATE_CYCLES = 250_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o
);
  localparam int unsigned CW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(GATE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/fc_bank.sv
`timescale 1ns/1ps
module fc_bank #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] pre_o,
  output logic [CNT_W-1:0] main_o,
  output logic [CNT_W-1:0] post_o
);
  logic [CNT_W-1:0] pre_q, main_q, post_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      main_q <= '0;
      post_q <= '0;
      seen_q <= 1'b0;
    end else if (clear_i) begin
      pre_q  <= '0;
      main_q <= '0;
      post_q <= '0;
      seen_q <= 1'b0;
    end else if (run_i) begin
      if (rise_i) begin
        seen_q <= 1'b1;
        main_q <= main_q + 1'b1;
        post_q <= '0;  // tail restarts at each edge
      end else if (seen_q) begin
        post_q <= post_q + 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end

  assign pre_o  = pre_q;
  assign main_o = main_q;
  assign post_o = post_q;
endmodule

// File: rtl/hyb_freq_counter.sv
`timescale 1ns/1ps
module hyb_freq_counter
  import fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 28,
  parameter int unsigned GATE_CYCLES = 250_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_i,
  output logic             bank_sel_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] rd_pre_o,
  output logic [CNT_W-1:0] rd_main_o,
  output logic [CNT_W-1:0] rd_post_o
);
  logic  rise;
  logic  gate_last;
  bank_e sel_q;
  logic  valid_q;

  logic [CNT_W-1:0] pre_w  [NUM_BANKS];
  logic [CNT_W-1:0] main_w [NUM_BANKS];
  logic [CNT_W-1:0] post_w [NUM_BANKS];

  fc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (meas_i),
    .rise_o (rise)
  );

  fc_gate_gen #(.GATE_CYCLES(GATE_CYCLES)) i_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_o (gate_last)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic is_idle;
      assign is_idle = (logic'(sel_q) == 1'(b));
      fc_bank #(.CNT_W(CNT_W)) i_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (gate_last & is_idle),
        .run_i   (~is_idle),
        .rise_i  (rise),
        .pre_o   (pre_w[b]),
        .main_o  (main_w[b]),
        .post_o  (post_w[b])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= BANK_A;
      valid_q <= 1'b0;
    end else begin
      valid_q <= gate_last;
      if (gate_last) sel_q <= (sel_q == BANK_A) ? BANK_B : BANK_A;
    end
  end

  assign bank_sel_o = logic'(sel_q);
  assign valid_o    = valid_q;
  assign rd_pre_o   = pre_w[sel_q];
  assign rd_main_o  = main_w[sel_q];
  assign rd_post_o  = post_w[sel_q];
endmodule

// File: rtl/fc_checker.sv
`timescale 1ns/1ps
module fc_checker #(
  parameter int unsigned CNT_W       = 28,
  parameter int unsigned GATE_CYCLES = 250_000_000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bank_sel_o,
  input logic             valid_o,
  input logic [CNT_W-1:0] rd_pre_o,
  input logic [CNT_W-1:0] rd_main_o,
  input logic [CNT_W-1:0] rd_post_o
);
  localparam logic [CNT_W:0] GATE_L = (CNT_W+1)'(GATE_CYCLES);
  localparam logic [CNT_W:0] MAIN_L = (CNT_W+1)'((GATE_CYCLES + 1) / 2);

  logic [31:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      since_q <= '0;
    else if (valid_o) since_q <= 32'd1;
    else              since_q <= since_q + 32'd1;
  end

  p_gate_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> since_q == GATE_CYCLES);
  p_sel_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> bank_sel_o != $past(bank_sel_o));
  p_readout_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(bank_sel_o) && $stable(rd_pre_o) && $stable(rd_main_o) && $stable(rd_post_o)));
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_pre_post_sum_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, rd_pre_o} + {1'b0, rd_post_o}) <= GATE_L);
  p_main_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, rd_main_o} <= MAIN_L);
  p_empty_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rd_main_o == '0) |-> ({1'b0, rd_pre_o} == GATE_L && rd_post_o == '0));
endmodule

bind hyb_freq_counter fc_checker #(.CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES)) i_fc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bank_sel_o (bank_sel_o),
  .valid_o    (valid_o),
  .rd_pre_o   (rd_pre_o),
  .rd_main_o  (rd_main_o),
  .rd_post_o  (rd_post_o)
);

// File: tb/test_hyb_freq_counter.sv
`timescale 1ns/1ps
module test_hyb_freq_counter;
  localparam int CNT_W = 28;
  localparam int N     = 60;

  logic clk = 1'b0;
  logic rst_n;
  logic meas;
  logic bank_sel, valid;
  logic [CNT_W-1:0] rd_pre, rd_main, rd_post;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  hyb_freq_counter #(.CNT_W(CNT_W), .GATE_CYCLES(N)) i_hyb_freq_counter (
    .clk_i(clk), .rst_ni(rst_n), .meas_i(meas),
    .bank_sel_o(bank_sel), .valid_o(valid),
    .rd_pre_o(rd_pre), .rd_main_o(rd_main), .rd_post_o(rd_post)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pre[2], m_main[2], m_post[2];
  bit m_seen[2];
  int m_gc, m_sel;
  bit m_valid;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        m_pre[b] = 0; m_main[b] = 0; m_post[b] = 0; m_seen[b] = 0;
      end
      m_gc = 0; m_sel = 0; m_valid = 0;
      hist = '{0, 0, 0};
    end else begin
      bit r;
      int act;
      hist.push_back(meas);
      r = hist[$-2] && !hist[$-3];  // rise sampled two edges ago
      if (hist.size() > 6) void'(hist.pop_front());
      act = 1 - m_sel;
      if (r) begin
        m_seen[act] = 1; m_main[act]++; m_post[act] = 0;
      end else if (m_seen[act]) m_post[act]++;
      else m_pre[act]++;
      if (m_gc == N - 1) begin
        m_gc = 0;
        m_pre[m_sel] = 0; m_main[m_sel] = 0; m_post[m_sel] = 0; m_seen[m_sel] = 0;
        m_sel = act;
        m_valid = 1;
      end else begin
        m_gc++;
        m_valid = 0;
      end
    end
  end

  longint h_pre, h_main, h_post;
  initial begin h_pre = 0; h_main = 0; h_post = 0; end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rd_pre == CNT_W'(m_pre[m_sel]), "R2 pre count", rd_pre, m_pre[m_sel]);
      check(rd_main == CNT_W'(m_main[m_sel]), "R3 main count", rd_main, m_main[m_sel]);
      check(rd_post == CNT_W'(m_post[m_sel]), "R4 post count", rd_post, m_post[m_sel]);
      check(bank_sel == m_sel[0], "R5 bank select", bank_sel, m_sel);
      check(valid == m_valid, "R7 valid pulse", valid, m_valid);
      if (valid) begin
        h_pre = rd_pre; h_main = rd_main; h_post = rd_post;
      end else begin
        check(rd_pre == h_pre && rd_main == h_main && rd_post == h_post,
              "R6 readout held", rd_pre + rd_main + rd_post, h_pre + h_main + h_post);
      end
    end
  end

  task automatic wait_valid();
    do @(negedge clk); while (!valid);
  endtask

  task automatic square(input int hi, input int lo, input int cycles);
    int n = 0;
    while (n < cycles) begin
      meas = 1'b1;
      repeat (hi) @(negedge clk);
      meas = 1'b0;
      repeat (lo) @(negedge clk);
      n += hi + lo;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    meas  = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_pre == 0 && rd_main == 0 && rd_post == 0, "R1 reset readout", rd_pre + rd_main + rd_post, 0);
    check(bank_sel == 0 && valid == 0, "R1 reset select/valid", {bank_sel, valid}, 0);
    rst_n = 1'b1;

    wait_valid();
    check(rd_pre == 2, "R8 pre with input high at release", rd_pre, 2);
    check(rd_main == 1, "R8 held level counted once", rd_main, 1);
    check(rd_post == N - 3, "R8 post with input high at release", rd_post, N - 3);
    check(bank_sel == 1, "R5 first swap to group B", bank_sel, 1);

    wait_valid();
    check(rd_pre == N && rd_main == 0 && rd_post == 0, "R9 gate without edges (high)", rd_pre, N);
    meas = 1'b0;
    wait_valid();
    wait_valid();
    check(rd_pre == N && rd_main == 0 && rd_post == 0, "R9 gate without edges (low)", rd_pre, N);

    square(3, 3, 3 * N);
    square(4, 3, 3 * N);
    square(1, 1, 2 * N);
    square(1, 5, 2 * N);
    for (int i = 0; i < 40; i++) square(1 + i % 3, 1 + (i * 7) % 5, 1);
    square(2, 3, 2 * N);
    wait_valid();
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R5 watchdog expired: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule